// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a byte-addressed memory reached over a two-wire serial bus, with one clock line and one data line. The memory holds 2048 bytes. An 11-bit location is formed from 3 block-select bits carried in the device byte and an 8-bit word address sent as the second byte. A fast system clock oversamples both bus lines. Start and stop conditions and SCL edges are found from the sampled levels. The slave pulls the data line low through an output-enable and never drives it high.

The block keeps one address pointer between transactions. A write transfer loads the pointer from the block-select bits and the word address, then stores each data byte at the pointer. During a write only the low 4 pointer bits advance, so a long burst wraps inside its 16-byte page. A read transfer starts from the pointer. In a random read, a write transfer that carries only the word address is followed by a repeated start and a read device byte. A current-address read sends the read device byte alone, and its block-select bits are ignored. During reads the pointer advances over the full 11-bit range after every byte.

Top module: `tws_eeprom`

## Requirements
- R1: After reset `sda_oe` is 0 and the address pointer is 0x000, so a current-address read issued first after reset returns the byte at 0x000. The memory contents are kept through reset.
- R2: The device byte is 8 bits sent MSB first: bits 7:4 are the device code 1010, bits 3:1 are the block-select bits, and bit 0 is the direction (1 = read). On a matching code the slave pulls SDA low during the 9th SCL high phase. `sda_oe` only changes while SCL is low, except that it is released at a start or stop.
- R3: A device byte whose bits 7:4 are not 1010 gets no acknowledge. Every later byte, including a well-formed device byte, is ignored until the next start condition.
- R4: A write transfer (device byte with bit 0 = 0, word address, data) stores the data byte at {block-select, word address}. Each of the three bytes is acknowledged.
- R5: In a multi-byte write only the low 4 address bits advance after each data byte, so the bytes wrap within the 16-byte page. Upper address bits never change during a write.
- R6: A random read (write device byte, word address, repeated start, read device byte) returns the byte at the given location, MSB first, one bit per SCL clock.
- R7: A current-address read ignores the block-select bits of its device byte and reads the location held by the pointer.
- R8: After each byte read, the pointer increments at the SCL falling edge that ends the 8th data bit. The increment covers the full 11 bits and wraps from 0x7FF to 0x000. When the master acknowledges, the next byte follows at once.
- R9: The pointer persists across transactions. After a data byte is written at address A, the pointer is A with its low 4 bits incremented modulo 16.
- R10: When the master does not acknowledge a read byte, the slave releases SDA before the following SCL low phase ends, and stays released through the stop condition.
- R11: A start condition at any bit position abandons the transfer in progress without changing the pointer, and the next byte is taken as a new device byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wired line |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume that the bus lines hold each level for several system clocks, longer than the synchronizer delay. They also assume the data line changes only while SCL is low, apart from start and stop conditions, and that the slave is released whenever the master makes a start or stop. The bench drives the bus as open-drain, with the line equal to the master level ANDed with the released slave. Each SCL quarter-phase lasts eight system clocks. Starts and stops are issued only after an acknowledge bit or a master NACK, when the slave has let go of the line.

// File: rtl/tws_pkg.sv
// Shared types and constants for the two-wire memory slave.
// Assumes an 8-bit device byte: 4-bit code, 3 block bits, direction bit.
package tws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } tws_state_e;

    localparam logic [3:0] TWS_DEV_CODE = 4'b1010;
endpackage

// File: rtl/tws_line_sampler.sv
// Synchronizes SCL and SDA into the system clock domain and flags SCL
// edges and start/stop conditions. Assumes bus levels last several clocks.
module tws_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    // Shift bus levels through the synchronizer; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_sync[SYNC_STAGES-1];
            sda_q    <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Derive edges and bus conditions from current and previous level.
    always_comb begin
        scl_lvl   = scl_sync[SYNC_STAGES-1];
        sda_lvl   = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/tws_regfile.sv
// Plain register-file storage: one synchronous write port, one
// combinational read port. Contents are not reset.
module tws_regfile #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte when the controller commits a write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tws_eeprom.sv
// Two-wire byte-addressed memory slave. Receives device byte, word
// address and data; serves random and current-address reads from a
// persistent pointer. Assumes BLK_W <= 3 and WORD_W == 8 (byte bus).
module tws_eeprom #(
    parameter int BLK_W       = 3,
    parameter int WORD_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import tws_pkg::*;

    localparam int ADDR_W = BLK_W + WORD_W;
    localparam logic [3:0] CNT_LAST = 4'd8;
    localparam logic [3:0] CNT_ACK  = 4'd9;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    tws_state_e        state;
    logic [3:0]        cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] outb;
    logic [ADDR_W-1:0] ptr;
    logic [BLK_W-1:0]  blk;
    logic              mack;
    logic              sda_oe_q;
    logic              mem_we;
    logic [WORD_W-1:0] rdata;

    tws_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    assign mem_we = (state == ST_WDATA) && scl_fall && (cnt == CNT_LAST);

    tws_regfile #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) i_mem (
        .clk  (clk),
        .we   (mem_we),
        .waddr(ptr),
        .wdata(shreg),
        .raddr(ptr),
        .rdata(rdata)
    );

    // Bus protocol controller: bit counting, acknowledge, pointer upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            outb     <= '0;
            ptr      <= '0;
            blk      <= '0;
            mack     <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (start_evt) begin
            state    <= ST_DEV;
            cnt      <= '0;
            sda_oe_q <= 1'b0;
        end else if (stop_evt) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        if (cnt < CNT_LAST) begin
                            shreg <= {shreg[WORD_W-2:0], sda_lvl};
                        end
                        cnt <= cnt + 4'd1;
                    end
                    if (scl_fall && cnt == CNT_LAST) begin
                        if (state == ST_DEV) begin
                            if (shreg[WORD_W-1 -: 4] == TWS_DEV_CODE) begin
                                sda_oe_q <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WADDR) begin
                            sda_oe_q <= 1'b1;
                            ptr      <= {blk, shreg};
                        end else begin
                            sda_oe_q <= 1'b1;
                            ptr      <= {ptr[ADDR_W-1:PAGE_W],
                                         ptr[PAGE_W-1:0] + PAGE_W'(1)};
                        end
                    end
                    if (scl_fall && cnt == CNT_ACK) begin
                        sda_oe_q <= 1'b0;
                        cnt      <= '0;
                        if (state == ST_DEV) begin
                            if (shreg[0]) begin
                                state    <= ST_RDATA;
                                outb     <= rdata;
                                sda_oe_q <= ~rdata[WORD_W-1];
                            end else begin
                                state <= ST_WADDR;
                                blk   <= shreg[BLK_W:1];
                            end
                        end else if (state == ST_WADDR) begin
                            state <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        if (cnt == CNT_LAST) begin
                            mack <= ~sda_lvl;
                        end
                        cnt <= cnt + 4'd1;
                    end
                    if (scl_fall) begin
                        if (cnt != '0 && cnt < CNT_LAST) begin
                            sda_oe_q <= ~outb[WORD_W-2];
                            outb     <= {outb[WORD_W-2:0], 1'b0};
                        end else if (cnt == CNT_LAST) begin
                            sda_oe_q <= 1'b0;
                            ptr      <= ptr + ADDR_W'(1);
                        end else if (cnt == CNT_ACK) begin
                            cnt <= '0;
                            if (mack) begin
                                outb     <= rdata;
                                sda_oe_q <= ~rdata[WORD_W-1];
                            end else begin
                                state    <= ST_IDLE;
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    sda_oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe = sda_oe_q;

    // R2: the slave only starts pulling SDA while SCL is low.
    p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_q) |-> !$past(scl_lvl));

    // R2: bit counter never passes the acknowledge slot.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_ACK);

    // R3: an idle (ignoring) slave keeps the line released.
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sda_oe_q);

    // R5: a committed write leaves the upper address bits alone.
    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !start_evt && !stop_evt) |=>
            ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

    // R8: end of a read byte advances the full pointer by one.
    p_read_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && scl_fall && cnt == CNT_LAST && !start_evt && !stop_evt)
            |=> ptr == $past(ptr) + ADDR_W'(1));

    // R10: a stop leaves the line released.
    p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe_q);

    // R11: a start restarts device byte reception from bit 0.
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_DEV && cnt == '0 && !sda_oe_q));
endmodule

// File: tb/test_tws_eeprom.sv
`timescale 1ns/1ps
module test_tws_eeprom;
    localparam int Q = 8;
    localparam int NVEC = 8;
    // {address[10:0], data[7:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {11'h010, 8'h5A}, {11'h011, 8'hA5}, {11'h0FF, 8'h01}, {11'h100, 8'hFE},
        {11'h255, 8'h3C}, {11'h4A7, 8'h96}, {11'h6C3, 8'h0F}, {11'h7FE, 8'hF0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tws_eeprom i_tws_eeprom (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_m),
        .sda_i (sda_line),
        .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        sda_m = b; qw();
        scl_m = 1'b1; qw();
        r = sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
        bit_xfer(1'b1, r);
        ack = !r;
    endtask

    task automatic rx_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b1, r);
            d = {d[6:0], r};
        end
        bit_xfer(!give_ack, r);
    endtask

    function automatic logic [7:0] dev(input logic [2:0] blk, input logic rd);
        return {4'b1010, blk, rd};
    endfunction

    task automatic wr1(input logic [10:0] a, input logic [7:0] d);
        logic ack;
        bus_start();
        tx_byte(dev(a[10:8], 1'b0), ack); chk(ack, "R2 dev ack", ack, 1);
        tx_byte(a[7:0], ack);             chk(ack, "R4 addr ack", ack, 1);
        tx_byte(d, ack);                  chk(ack, "R4 data ack", ack, 1);
        bus_stop();
    endtask

    task automatic rd_rand(input logic [10:0] a, output logic [7:0] d);
        logic ack;
        bus_start();
        tx_byte(dev(a[10:8], 1'b0), ack);
        tx_byte(a[7:0], ack);
        bus_start();
        tx_byte(dev(a[10:8], 1'b1), ack); chk(ack, "R2 read dev ack", ack, 1);
        rx_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic rd_cur(input logic [2:0] blk, output logic [7:0] d);
        logic ack;
        bus_start();
        tx_byte(dev(blk, 1'b1), ack); chk(ack, "R7 cur dev ack", ack, 1);
        rx_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        logic ack, r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1; qw();
        // R1: released after reset
        chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);

        // R4 / R6: table of write-then-read vectors
        for (int i = 0; i < NVEC; i++) wr1(VEC[i][18:8], VEC[i][7:0]);
        for (int i = 0; i < NVEC; i++) begin
            rd_rand(VEC[i][18:8], d);
            chk(d == VEC[i][7:0], "R6 random read", d, VEC[i][7:0]);
        end

        // R5: page wrap within 16 bytes
        wr1(11'h300, 8'hEE);
        bus_start();
        tx_byte(dev(3'h2, 1'b0), ack);
        tx_byte(8'hFE, ack);
        tx_byte(8'h11, ack);
        tx_byte(8'h22, ack);
        tx_byte(8'h33, ack); chk(ack, "R5 page ack", ack, 1);
        bus_stop();
        rd_rand(11'h2F0, d); chk(d == 8'h33, "R5 wrap to page base", d, 8'h33);
        rd_rand(11'h2FF, d); chk(d == 8'h22, "R5 page end", d, 8'h22);
        rd_rand(11'h2FE, d); chk(d == 8'h11, "R5 page start", d, 8'h11);
        rd_rand(11'h300, d); chk(d == 8'hEE, "R5 next page untouched", d, 8'hEE);

        // R9 / R7: pointer after write, block bits ignored
        wr1(11'h124, 8'h88);
        wr1(11'h123, 8'h77);
        rd_cur(3'h0, d); chk(d == 8'h88, "R9 ptr after write", d, 8'h88);
        wr1(11'h120, 8'h44);
        wr1(11'h12F, 8'h99);
        rd_cur(3'h5, d); chk(d == 8'h44, "R7 R9 in-page wrap ptr", d, 8'h44);

        // R8: sequential read wrapping 0x7FF -> 0x000
        wr1(11'h7FF, 8'hC3);
        wr1(11'h000, 8'h3C);
        wr1(11'h001, 8'h5E);
        bus_start();
        tx_byte(dev(3'h7, 1'b0), ack);
        tx_byte(8'hFF, ack);
        bus_start();
        tx_byte(dev(3'h7, 1'b1), ack);
        rx_byte(1'b1, d);
        rx_byte(1'b0, d2);
        bus_stop();
        chk(d == 8'hC3, "R8 first byte", d, 8'hC3);
        chk(d2 == 8'h3C, "R8 wrap to 0x000", d2, 8'h3C);
        rd_cur(3'h3, d); chk(d == 8'h5E, "R8 ptr after wrap", d, 8'h5E);

        // R3: wrong device code is not acked and bus ignored until start
        bus_start();
        tx_byte(8'h90, ack); chk(!ack, "R3 bad code no ack", ack, 0);
        tx_byte(8'hA0, ack); chk(!ack, "R3 ignored until start", ack, 0);
        tx_byte(8'hBB, ack);
        bus_stop();
        rd_rand(11'h010, d); chk(d == 8'h5A, "R3 memory unchanged", d, 8'h5A);

        // R11: start mid-byte aborts, pointer untouched (now 0x011)
        bus_start();
        tx_byte(dev(3'h1, 1'b0), ack);
        bit_xfer(1'b1, r); bit_xfer(1'b0, r); bit_xfer(1'b1, r);
        bus_start();
        tx_byte(dev(3'h5, 1'b1), ack); chk(ack, "R11 restart ack", ack, 1);
        rx_byte(1'b0, d);
        chk(d == 8'hA5, "R11 pointer kept", d, 8'hA5);
        // R10: released after master NACK and through stop
        chk(sda_oe == 1'b0, "R10 release after nack", sda_oe, 0);
        bus_stop();
        qw();
        chk(sda_oe == 1'b0 && sda_line == 1'b1, "R10 released after stop", sda_oe, 0);

        // R1: pointer returns to 0x000 on reset, memory kept
        wr1(11'h000, 8'h6B);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1; qw();
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        rd_cur(3'h6, d); chk(d == 8'h6B, "R1 pointer reset", d, 8'h6B);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule